// File: doc/BRIEF.md
# CAN Controller Operating Mode Manager

This block decides which operating mode a CAN controller is in, and it tells the protocol engine what that mode allows. The host writes a control byte through decoded SPI commands. Bits 7:5 of that byte request a mode, bit 4 enables wake-up on bus activity and bit 3 is a software reset. Bit 2 and bits 1:0 are stored so that the host can read them back, and this block gives them no meaning. From the requested mode and the bus conditions, the block works out the active mode. It then drives per-mode strobes: permission to drive the bus, the internal loopback path, receive enable and permission to write the configuration registers.

Sleep needs a quiet system. A sleep request is honoured only when the bus is idle and the transmit FIFO is empty. Until then the request waits, and the host can replace it by writing another mode. While the controller is asleep, bus activity wakes it into monitor mode only if wake-up is enabled. A wake-up sets a flag, and that flag reaches the interrupt line only through an enable input. There are three reset sources: a pin, an SPI command and the control-byte bit. The first two restore all the defaults. The control bit holds the engine in reset for as long as it stays set.

Top module: `can_mode_mgr`

## Requirements
- R1: The mode field decodes as 000 normal, 001 loopback, 010 monitor, 011 sleep, and any value with bit 7 set as initialization. After a control write (opcode 0x14), `mode_o` shows the new mode on the next cycle, with initialization shown as 100.
- R2: After reset, `mode_o` is 100 and the control byte reads back as 0x80, which means wake-up enable 0 and reset bit 0. `wake_flag`, `irq` and `core_rst` are all 0 after reset.
- R3: `cfg_wr_ok` is 1 exactly while the active mode is initialization.
- R4: Sleep becomes active only on a cycle in which `bus_active` is 0 and `txfifo_empty` is 1.
- R5: A sleep request that cannot be honoured leaves the mode unchanged and stays pending until the bus is idle and the FIFO is empty. A later write of a different mode cancels it.
- R6: With wake-up enable (bit 4) set, bus activity during sleep moves the mode to monitor and sets `wake_flag` on the next cycle. It also changes the stored mode field to 010.
- R7: With wake-up enable clear, bus activity during sleep is ignored. Only a host write leaves sleep.
- R8: `irq` is high only while `wake_flag` is set and `wake_irq_en` was high in the preceding cycle.
- R9: `tx_drive_en` is 1 only in normal mode. `loopback_en` is 1 only in loopback mode. `rx_en` is 1 in normal, loopback and monitor modes.
- R10: Writing bit 3 as 1 forces initialization and holds `core_rst` high. Bit 3 keeps reading as 1 until the host writes 0, and that write then applies its mode field.
- R11: Taking `mr_pin` high, or sending opcode 0x56, resets the control byte to 0x80 and the mode to initialization, clears `wake_flag` and pulses `core_rst`.
- R12: A read (opcode 0xD2) returns the stored control byte on `rd_data`, with `rd_valid` high, one cycle later.
- R13: A pulse on `wake_flag_clr` clears `wake_flag` unless a new wake-up occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_valid | input | 1 | Decoded SPI command strobe |
| spi_op | input | 8 | Command opcode |
| spi_wdata | input | 8 | Data byte for a control write |
| bus_active | input | 1 | Bus activity seen by the receiver |
| txfifo_empty | input | 1 | Transmit FIFO holds no frame |
| mr_pin | input | 1 | Master reset pin, active high |
| wake_irq_en | input | 1 | Wake-up interrupt enable |
| wake_flag_clr | input | 1 | Clears the wake-up flag |
| mode_o | output | 3 | Active operating mode |
| tx_drive_en | output | 1 | Engine may drive the bus |
| loopback_en | output | 1 | Internal transmit-to-receive path |
| rx_en | output | 1 | Receiver enabled |
| cfg_wr_ok | output | 1 | Bit timing and filter writes allowed |
| core_rst | output | 1 | Reset to the protocol engine |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Control byte read back |
| wake_flag | output | 1 | Wake-up interrupt flag |
| irq | output | 1 | Interrupt line |

## Verification
The mode sequencer is driven with sleep requests under each blocking condition: bus busy, FIFO non-empty, and both conditions clear. This separates immediate entry, a held request and a request cancelled by another mode write. Bus activity during sleep is applied with wake-up disabled, with it enabled and the interrupt masked, and with it enabled and the interrupt unmasked. Together these runs separate an ignored wake-up, a flag-only wake-up and an interrupting wake-up. The three reset sources are each applied from a non-initialization mode, which shows the difference between the held software reset and the one-shot pin and command resets.

// File: rtl/cmm_pkg.sv
package cmm_pkg;
  localparam int CTRL_W    = 8;
  localparam int MODE_W    = 3;
  localparam int MODE_LSB  = 5;
  localparam int WAKE_BIT  = 4;
  localparam int SWRST_BIT = 3;
  localparam logic [CTRL_W-1:0] CTRL_DEFAULT = 8'h80;

  typedef enum logic [MODE_W-1:0] {
    MD_NORMAL = 3'b000,
    MD_LOOP   = 3'b001,
    MD_MON    = 3'b010,
    MD_SLEEP  = 3'b011,
    MD_INIT   = 3'b100
  } mode_e;

  function automatic mode_e decode_mode(input logic [MODE_W-1:0] f);
    if (f[MODE_W-1]) return MD_INIT;
    return mode_e'(f);
  endfunction
endpackage

// File: rtl/cmm_ctrl_reg.sv
module cmm_ctrl_reg
  import cmm_pkg::*;
(
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              wake_ev,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              swrst_next,
  output logic              wake_en
);
  always_ff @(posedge clk) begin
    if (hard_rst)
      ctrl_q <= CTRL_DEFAULT;
    else if (wr_en)
      ctrl_q <= wdata;
    else if (wake_ev)
      ctrl_q[MODE_LSB +: MODE_W] <= MD_MON;
  end

  always_comb begin
    if (hard_rst)   swrst_next = 1'b0;
    else if (wr_en) swrst_next = wdata[SWRST_BIT];
    else            swrst_next = ctrl_q[SWRST_BIT];
  end

  assign wake_en = ctrl_q[WAKE_BIT];
endmodule

// File: rtl/cmm_mode_seq.sv
module cmm_mode_seq
  import cmm_pkg::*;
(
  input  logic              clk,
  input  logic              hard_rst,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] req_field,
  input  logic              swrst_next,
  input  logic              wake_en,
  input  logic              bus_active,
  input  logic              txfifo_empty,
  output mode_e             mode_q,
  output mode_e             mode_next,
  output logic              wake_ev
);
  logic  pend_q, pend_n;
  logic  quiet;
  mode_e req;

  assign quiet = !bus_active && txfifo_empty;
  assign req   = decode_mode(req_field);
  assign wake_ev = !hard_rst && !wr_en && !swrst_next &&
                   (mode_q == MD_SLEEP) && wake_en && bus_active;

  always_comb begin
    mode_next = mode_q;
    pend_n    = pend_q;
    if (hard_rst || swrst_next) begin
      mode_next = MD_INIT;
      pend_n    = 1'b0;
    end else if (wr_en) begin
      if (req == MD_SLEEP && !quiet) begin
        pend_n = 1'b1;
      end else begin
        mode_next = req;
        pend_n    = 1'b0;
      end
    end else if (wake_ev) begin
      mode_next = MD_MON;
    end else if (pend_q && quiet) begin
      mode_next = MD_SLEEP;
      pend_n    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    mode_q <= mode_next;
    pend_q <= pend_n;
  end
endmodule

// File: rtl/cmm_irq.sv
module cmm_irq (
  input  logic clk,
  input  logic clear_all,
  input  logic wake_ev,
  input  logic flag_clr,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);
  logic flag_n;

  always_comb begin
    if (clear_all)    flag_n = 1'b0;
    else if (wake_ev) flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
    else              flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    flag_q <= flag_n;
    irq_q  <= flag_n && irq_en;
  end
endmodule

// File: rtl/can_mode_mgr.sv
module can_mode_mgr
  import cmm_pkg::*;
#(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OP_CTRL_WR = 8'h14,
  parameter logic [OP_W-1:0] OP_CTRL_RD = 8'hD2,
  parameter logic [OP_W-1:0] OP_MRST    = 8'h56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_valid,
  input  logic [OP_W-1:0]   spi_op,
  input  logic [CTRL_W-1:0] spi_wdata,
  input  logic              bus_active,
  input  logic              txfifo_empty,
  input  logic              mr_pin,
  input  logic              wake_irq_en,
  input  logic              wake_flag_clr,
  output logic [MODE_W-1:0] mode_o,
  output logic              tx_drive_en,
  output logic              loopback_en,
  output logic              rx_en,
  output logic              cfg_wr_ok,
  output logic              core_rst,
  output logic              rd_valid,
  output logic [CTRL_W-1:0] rd_data,
  output logic              wake_flag,
  output logic              irq
);
  logic              hard_rst, wr_en, rd_en;
  logic [CTRL_W-1:0] ctrl_q;
  logic              swrst_next, wake_en_w, wake_ev;
  mode_e             mode_q, mode_next;

  assign wr_en    = spi_valid && (spi_op == OP_CTRL_WR);
  assign rd_en    = spi_valid && (spi_op == OP_CTRL_RD);
  assign hard_rst = rst || mr_pin || (spi_valid && spi_op == OP_MRST);

  cmm_ctrl_reg u_ctrl (
    .clk(clk), .hard_rst(hard_rst), .wr_en(wr_en), .wdata(spi_wdata),
    .wake_ev(wake_ev), .ctrl_q(ctrl_q), .swrst_next(swrst_next),
    .wake_en(wake_en_w)
  );

  cmm_mode_seq u_seq (
    .clk(clk), .hard_rst(hard_rst), .wr_en(wr_en),
    .req_field(spi_wdata[MODE_LSB +: MODE_W]), .swrst_next(swrst_next),
    .wake_en(wake_en_w), .bus_active(bus_active), .txfifo_empty(txfifo_empty),
    .mode_q(mode_q), .mode_next(mode_next), .wake_ev(wake_ev)
  );

  cmm_irq u_irq (
    .clk(clk), .clear_all(hard_rst || swrst_next), .wake_ev(wake_ev),
    .flag_clr(wake_flag_clr), .irq_en(wake_irq_en),
    .flag_q(wake_flag), .irq_q(irq)
  );

  assign mode_o = mode_q;

  always_ff @(posedge clk) begin
    tx_drive_en <= (mode_next == MD_NORMAL);
    loopback_en <= (mode_next == MD_LOOP);
    rx_en       <= (mode_next == MD_NORMAL) || (mode_next == MD_LOOP) ||
                   (mode_next == MD_MON);
    cfg_wr_ok   <= (mode_next == MD_INIT);
    core_rst    <= hard_rst || swrst_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= ctrl_q;
    end
  end
endmodule

// File: rtl/cmm_checker.sv
module cmm_checker
  import cmm_pkg::*;
#(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OP_CTRL_RD = 8'hD2
) (
  input logic              clk,
  input logic              rst,
  input logic              spi_valid,
  input logic [OP_W-1:0]   spi_op,
  input logic              bus_active,
  input logic              txfifo_empty,
  input logic              mr_pin,
  input logic              wake_irq_en,
  input logic              wake_en,
  input logic [MODE_W-1:0] mode_o,
  input logic              tx_drive_en,
  input logic              cfg_wr_ok,
  input logic              core_rst,
  input logic              rd_valid,
  input logic              wake_flag,
  input logic              irq
);
  assert_sleep_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_SLEEP && $past(mode_o) != MD_SLEEP) |-> $past(!bus_active && txfifo_empty));

  assert_cfg_only_init_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_wr_ok |-> mode_o == MD_INIT);

  assert_no_drive_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_o != MD_NORMAL) |-> !tx_drive_en);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(wake_irq_en) && wake_flag));

  assert_wake_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    $past(mode_o == MD_SLEEP && !wake_en && !spi_valid && !mr_pin) |-> mode_o == MD_SLEEP);

  assert_wake_flag_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_o) == MD_SLEEP && mode_o == MD_MON && !$past(spi_valid)) |-> wake_flag);

  assert_pin_reset_R11: assert property (@(posedge clk) disable iff (rst)
    $past(mr_pin) |-> (mode_o == MD_INIT && core_rst && !wake_flag));

  assert_read_timing_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(spi_valid && spi_op == OP_CTRL_RD));
endmodule

bind can_mode_mgr cmm_checker #(.OP_W(OP_W), .OP_CTRL_RD(OP_CTRL_RD)) u_chk (
  .clk(clk), .rst(rst), .spi_valid(spi_valid), .spi_op(spi_op),
  .bus_active(bus_active), .txfifo_empty(txfifo_empty), .mr_pin(mr_pin),
  .wake_irq_en(wake_irq_en), .wake_en(wake_en_w), .mode_o(mode_o),
  .tx_drive_en(tx_drive_en), .cfg_wr_ok(cfg_wr_ok), .core_rst(core_rst),
  .rd_valid(rd_valid), .wake_flag(wake_flag), .irq(irq)
);

// File: tb/tb_can_mode_mgr.sv
`timescale 1ns/1ps
module tb_can_mode_mgr;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_valid = 1'b0;
  logic [7:0] spi_op = '0, spi_wdata = '0;
  logic bus_active = 1'b0, txfifo_empty = 1'b1, mr_pin = 1'b0;
  logic wake_irq_en = 1'b0, wake_flag_clr = 1'b0;
  logic [2:0] mode_o;
  logic tx_drive_en, loopback_en, rx_en, cfg_wr_ok, core_rst, rd_valid, wake_flag, irq;
  logic [7:0] rd_data;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_mgr dut (
    .clk(clk), .rst(rst), .spi_valid(spi_valid), .spi_op(spi_op),
    .spi_wdata(spi_wdata), .bus_active(bus_active), .txfifo_empty(txfifo_empty),
    .mr_pin(mr_pin), .wake_irq_en(wake_irq_en), .wake_flag_clr(wake_flag_clr),
    .mode_o(mode_o), .tx_drive_en(tx_drive_en), .loopback_en(loopback_en),
    .rx_en(rx_en), .cfg_wr_ok(cfg_wr_ok), .core_rst(core_rst),
    .rd_valid(rd_valid), .rd_data(rd_data), .wake_flag(wake_flag), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi(input logic [7:0] op, input logic [7:0] d);
    spi_valid = 1'b1; spi_op = op; spi_wdata = d;
    @(negedge clk);
    spi_valid = 1'b0;
  endtask

  task automatic read_ctrl(input string req, input logic [7:0] exp);
    spi(8'hD2, 8'h00);
    chk(req, "rd_valid", rd_valid, 1);
    chk(req, "rd_data", rd_data, exp);
  endtask

  task automatic t_reset;
    tick(1);
    chk("R2", "mode", mode_o, 3'b100);
    chk("R2", "core_rst", core_rst, 0);
    chk("R2", "flag/irq", {wake_flag, irq}, 0);
    chk("R3", "cfg_wr_ok in init", cfg_wr_ok, 1);
    read_ctrl("R2", 8'h80);
  endtask

  task automatic t_modes;
    spi(8'h14, 8'h00);
    chk("R1", "normal", mode_o, 3'b000);
    chk("R9", "tx/lb/rx normal", {tx_drive_en, loopback_en, rx_en}, 3'b101);
    chk("R3", "cfg off", cfg_wr_ok, 0);
    spi(8'h14, 8'h20);
    chk("R1", "loopback", mode_o, 3'b001);
    chk("R9", "tx/lb/rx loop", {tx_drive_en, loopback_en, rx_en}, 3'b011);
    spi(8'h14, 8'h40);
    chk("R1", "monitor", mode_o, 3'b010);
    chk("R9", "tx/lb/rx mon", {tx_drive_en, loopback_en, rx_en}, 3'b001);
    spi(8'h14, 8'hE0);
    chk("R1", "1xx is init", mode_o, 3'b100);
    chk("R3", "cfg on", cfg_wr_ok, 1);
    spi(8'h14, 8'h07);
    read_ctrl("R12", 8'h07);
  endtask

  task automatic t_sleep_gate;
    spi(8'h14, 8'h40);
    bus_active = 1'b1;
    spi(8'h14, 8'h60);
    chk("R4", "busy blocks sleep", mode_o, 3'b010);
    bus_active = 1'b0; txfifo_empty = 1'b0;
    tick(2);
    chk("R5", "pending with fifo full", mode_o, 3'b010);
    txfifo_empty = 1'b1;
    tick(1);
    chk("R5", "pending taken when quiet", mode_o, 3'b011);
    spi(8'h14, 8'h40);
    bus_active = 1'b1;
    spi(8'h14, 8'h60);
    spi(8'h14, 8'h00);
    bus_active = 1'b0;
    tick(2);
    chk("R5", "cancelled by other write", mode_o, 3'b000);
  endtask

  task automatic t_wake_off;
    spi(8'h14, 8'h60);
    chk("R4", "sleep when quiet", mode_o, 3'b011);
    chk("R9", "sleep strobes", {tx_drive_en, rx_en, cfg_wr_ok}, 3'b000);
    bus_active = 1'b1;
    tick(3);
    chk("R7", "stays asleep", mode_o, 3'b011);
    chk("R7", "no flag", wake_flag, 0);
    bus_active = 1'b0;
    spi(8'h14, 8'h40);
    chk("R7", "host write leaves sleep", mode_o, 3'b010);
  endtask

  task automatic t_wake_on;
    wake_irq_en = 1'b0;
    spi(8'h14, 8'h70);
    chk("R4", "sleep w/ wake", mode_o, 3'b011);
    bus_active = 1'b1;
    tick(1);
    bus_active = 1'b0;
    chk("R6", "woke to monitor", mode_o, 3'b010);
    chk("R6", "flag set", wake_flag, 1);
    chk("R8", "irq masked", irq, 0);
    read_ctrl("R6", 8'h50);
    wake_flag_clr = 1'b1; tick(1); wake_flag_clr = 1'b0;
    chk("R13", "flag cleared", wake_flag, 0);
    wake_irq_en = 1'b1;
    spi(8'h14, 8'h70);
    bus_active = 1'b1;
    tick(1);
    bus_active = 1'b0;
    chk("R8", "irq unmasked", irq, 1);
    wake_flag_clr = 1'b1; tick(1); wake_flag_clr = 1'b0;
    chk("R13", "flag and irq drop", {wake_flag, irq}, 0);
    wake_irq_en = 1'b0;
  endtask

  task automatic t_swrst;
    spi(8'h14, 8'h08);
    chk("R10", "held in init", mode_o, 3'b100);
    chk("R10", "core_rst", core_rst, 1);
    tick(2);
    chk("R10", "core_rst held", core_rst, 1);
    read_ctrl("R10", 8'h08);
    spi(8'h14, 8'h20);
    chk("R10", "released to loopback", mode_o, 3'b001);
    chk("R10", "core_rst low", core_rst, 0);
  endtask

  task automatic t_hard_rst;
    spi(8'h14, 8'h10);
    mr_pin = 1'b1; tick(1); mr_pin = 1'b0;
    chk("R11", "pin: init + core_rst", {mode_o, core_rst}, 4'b1001);
    tick(1);
    chk("R11", "pin: core_rst pulse ends", core_rst, 0);
    read_ctrl("R11", 8'h80);
    spi(8'h14, 8'h30);
    spi(8'h56, 8'h00);
    chk("R11", "cmd: init + core_rst", {mode_o, core_rst}, 4'b1001);
    read_ctrl("R11", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modes();
    t_sleep_gate();
    t_wake_off();
    t_wake_on();
    t_swrst();
    t_hard_rst();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule